// File: doc/BRIEF.md
# Dual-Rail Three-Valued Logic Unit

This block evaluates logic operations over three-valued bits (0, 1 and unknown) using only two-valued hardware. Each operand is presented as a pair of equal-width vectors. One holds the defined value and the other flags which positions are unknown. Internally every bit is widened to three one-hot rails: known-zero, known-one and unknown. The operation runs on those rails and the result is packed back into a value/mask pair.

The unit is purely combinational. A 4-bit opcode selects a bitwise operation (invert, and, or, xor, xnor, per-bit select) or a single-bit operation (reductions, logical negation, equality, inequality). Unknowns propagate only as far as they must: a known 0 masks an unknown in an and, a known 1 masks it in an or, and an unknown select still gives a defined bit when both data bits agree. It suits equivalence and reset-sensitivity models, where pessimism has to be exact and no simulator unknowns are available.

Top module: `xrail_logic_unit`

## Requirements
- R1: On every output bit, `y_d` is 0 wherever `y_x` is 1, so no bit is reported both defined-one and unknown.
- R2: Where an input mask bit (`a_x`, `b_x`, `s_x`) is 1, the matching value bit has no effect on the result.
- R3: Opcode 0 (invert): each result bit is the complement of `a`, and an unknown stays unknown.
- R4: Opcode 1 (and, per bit): the result is 0 if either bit is known 0, 1 if both are known 1, and unknown otherwise.
- R5: Opcode 2 (or, per bit): the result is 1 if either bit is known 1, 0 if both are known 0, and unknown otherwise.
- R6: Opcodes 3 (xor) and 4 (xnor), per bit: the result is unknown if either bit is unknown, and otherwise the exclusive-or of the bits, or its complement for xnor.
- R7: Opcode 5 (select, per bit): a known select of 0 passes `a` and a known select of 1 passes `b`. An unknown select gives the common value when `a` and `b` are both known and equal, and unknown otherwise.
- R8: Opcodes 6 (reduce-and) and 7 (reduce-or): reduce-and is 0 if any bit of `a` is known 0, 1 if all bits are known 1, and unknown otherwise. Reduce-or is 1 if any bit is known 1, 0 if all bits are known 0, and unknown otherwise.
- R9: Opcode 8 (reduce-xor): the result is unknown if any bit of `a` is unknown, and otherwise the parity of `a`.
- R10: Opcode 9 (logical not): the result is 1 if every bit of `a` is known 0, 0 if any bit is known 1, and unknown otherwise.
- R11: Opcode 10 (equal): the result is 0 if some position has both bits known and different. Otherwise it is unknown if any position holds an unknown, and otherwise 1. Opcode 11 (not equal) is the complement, with unknown kept as unknown.
- R12: For opcodes 6 to 11, the answer is in bit 0 and every higher result bit is a defined 0.
- R13: Opcodes 12 to 15 return every result bit as unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| a_d | input | W | Operand A defined value |
| a_x | input | W | Operand A unknown mask |
| b_d | input | W | Operand B defined value |
| b_x | input | W | Operand B unknown mask |
| s_d | input | W | Per-bit select defined value (opcode 5) |
| s_x | input | W | Per-bit select unknown mask (opcode 5) |
| y_d | output | W | Result defined value, 0 where unknown |
| y_x | output | W | Result unknown mask |

## Verification
The block holds no state, so a wrong internal rail shows on `y_d`/`y_x` in the same cycle as the stimulus that exposes it. A stuck or non-exclusive rail shows up in one of two ways: as a bit reported both one and unknown, or as a masking rule that goes wrong. For example, an and-with-known-zero may still report unknown, or an unknown select may fail to merge equal data. The bench drives every combination of three-valued operands at a small width for each opcode. It places varying junk under masked value bits, so a leak of a masked bit into the logic gives a mismatch at once.

// File: rtl/xrl_pkg.sv
package xrl_pkg;

   typedef enum logic [3:0] {
      OP_INV  = 4'd0,
      OP_AND  = 4'd1,
      OP_OR   = 4'd2,
      OP_XOR  = 4'd3,
      OP_XNOR = 4'd4,
      OP_SEL  = 4'd5,
      OP_RAND = 4'd6,
      OP_ROR  = 4'd7,
      OP_RXOR = 4'd8,
      OP_LNOT = 4'd9,
      OP_EQ   = 4'd10,
      OP_NE   = 4'd11
   } xrl_op_e;

   localparam int unsigned OP_BITS = 4;

   // true for operations whose answer is a single bit
   function automatic logic op_is_scalar(input logic [OP_BITS-1:0] code);
      return (code >= OP_RAND) && (code <= OP_NE);
   endfunction

   // true for per-bit operations
   function automatic logic op_is_bitwise(input logic [OP_BITS-1:0] code);
      return code <= OP_SEL;
   endfunction

endpackage

// File: rtl/xrl_rail_enc.sv
module xrl_rail_enc #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] val_d,
   input  logic [W-1:0] val_x,
   output logic [W-1:0] r0,
   output logic [W-1:0] r1,
   output logic [W-1:0] rx
);

   if (W < 1) begin : g_bad_width
      $error("xrl_rail_enc: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      // a masked value bit is discarded here, before any rail logic
      assign r1[i] = val_d[i] & ~val_x[i];
      assign r0[i] = ~val_d[i] & ~val_x[i];
      assign rx[i] = val_x[i];

      always_comb begin
         // R2
         mask_drop_chk: assert (!(val_x[i] && (r0[i] || r1[i])));
      end
   end

endmodule

// File: rtl/xrl_bitwise.sv
module xrl_bitwise
   import xrl_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [OP_BITS-1:0] op,
   input  logic [W-1:0]       a0,
   input  logic [W-1:0]       a1,
   input  logic [W-1:0]       ax,
   input  logic [W-1:0]       b0,
   input  logic [W-1:0]       b1,
   input  logic [W-1:0]       bx,
   input  logic [W-1:0]       s0,
   input  logic [W-1:0]       s1,
   output logic [W-1:0]       y0,
   output logic [W-1:0]       y1,
   output logic [W-1:0]       yx
);

   // shared dominance terms
   logic [W-1:0] and_zero, and_one;
   logic [W-1:0] or_zero, or_one;
   logic [W-1:0] any_x, par1;
   logic [W-1:0] sel_one, sel_zero;

   always_comb begin
      and_zero = a0 | b0;
      and_one  = a1 & b1;
      or_one   = a1 | b1;
      or_zero  = a0 & b0;
      any_x    = ax | bx;
      par1     = a1 ^ b1;
      sel_one  = (a1 | s1) & (b1 | s0);
      sel_zero = (a0 | s1) & (b0 | s0);
   end

   always_comb begin
      y0 = '0;
      y1 = '0;
      yx = '1;
      unique case (op)
         OP_INV: begin
            y0 = a1;
            y1 = a0;
            yx = ax;
         end
         OP_AND: begin
            y0 = and_zero;
            y1 = and_one;
            yx = ~(and_zero | and_one);
         end
         OP_OR: begin
            y0 = or_zero;
            y1 = or_one;
            yx = ~(or_zero | or_one);
         end
         OP_XOR: begin
            yx = any_x;
            y1 = par1 & ~any_x;
            y0 = ~(y1 | any_x);
         end
         OP_XNOR: begin
            yx = any_x;
            y0 = par1 & ~any_x;
            y1 = ~(y0 | any_x);
         end
         OP_SEL: begin
            y0 = sel_zero;
            y1 = sel_one;
            yx = ~(sel_zero | sel_one);
         end
         default: begin
            y0 = '0;
            y1 = '0;
            yx = '1;
         end
      endcase
   end

   for (genvar i = 0; i < W; i++) begin : g_chk
      always_comb begin
         if (op == OP_AND && (a0[i] || b0[i])) begin
            // R4
            and_mask_chk: assert (y0[i] && !yx[i]);
         end
         if (op == OP_OR && (a1[i] || b1[i])) begin
            // R5
            or_mask_chk: assert (y1[i] && !yx[i]);
         end
         if ((op == OP_XOR || op == OP_XNOR) && (ax[i] || bx[i])) begin
            // R6
            xor_unknown_chk: assert (yx[i]);
         end
         if (op_is_bitwise(op)) begin
            // R1
            bit_onehot_chk: assert ($onehot({y0[i], y1[i], yx[i]}));
         end
      end
   end

endmodule

// File: rtl/xrl_scalar.sv
module xrl_scalar
   import xrl_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [OP_BITS-1:0] op,
   input  logic [W-1:0]       a0,
   input  logic [W-1:0]       a1,
   input  logic [W-1:0]       ax,
   input  logic [W-1:0]       b1,
   input  logic [W-1:0]       bx,
   output logic               z0,
   output logic               z1,
   output logic               zx
);

   logic any0, any1, all0, all1, anyx, parity;
   logic [W-1:0] pos_x, pos_diff;
   logic diff_known, cmp_x;

   always_comb begin
      any0   = |a0;
      any1   = |a1;
      all0   = &a0;
      all1   = &a1;
      anyx   = |ax;
      parity = ^a1;
      pos_x    = ax | bx;
      pos_diff = (a1 ^ b1) & ~pos_x;
      diff_known = |pos_diff;
      cmp_x      = (|pos_x) & ~diff_known;
   end

   always_comb begin
      z0 = 1'b0;
      z1 = 1'b0;
      zx = 1'b1;
      unique case (op)
         OP_RAND: begin
            z0 = any0;
            z1 = all1;
            zx = ~(any0 | all1);
         end
         OP_ROR: begin
            z1 = any1;
            z0 = all0;
            zx = ~(any1 | all0);
         end
         OP_RXOR: begin
            zx = anyx;
            z1 = parity & ~anyx;
            z0 = ~parity & ~anyx;
         end
         OP_LNOT: begin
            z0 = any1;
            z1 = all0;
            zx = ~(any1 | all0);
         end
         OP_EQ: begin
            z0 = diff_known;
            zx = cmp_x;
            z1 = ~(diff_known | cmp_x);
         end
         OP_NE: begin
            z1 = diff_known;
            zx = cmp_x;
            z0 = ~(diff_known | cmp_x);
         end
         default: begin
            z0 = 1'b0;
            z1 = 1'b0;
            zx = 1'b1;
         end
      endcase
   end

   always_comb begin
      if (op == OP_EQ && |((a1 ^ b1) & ~(ax | bx))) begin
         // R11
         eq_known_diff_chk: assert (z0 && !zx);
      end
      if (op == OP_RXOR && |ax) begin
         // R9
         rxor_unknown_chk: assert (zx);
      end
      if (op_is_scalar(op)) begin
         // R1
         scalar_onehot_chk: assert ($onehot({z0, z1, zx}));
      end
   end

endmodule

// File: rtl/xrl_rail_dec.sv
module xrl_rail_dec #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] r1,
   input  logic [W-1:0] rx,
   output logic [W-1:0] val_d,
   output logic [W-1:0] val_x
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign val_d[i] = r1[i];
      assign val_x[i] = rx[i];
   end

   always_comb begin
      // R1
      out_clean_chk: assert ((val_d & val_x) == '0);
   end

endmodule

// File: rtl/xrail_logic_unit.sv
module xrail_logic_unit
   import xrl_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] a_d,
   input  logic [W-1:0] a_x,
   input  logic [W-1:0] b_d,
   input  logic [W-1:0] b_x,
   input  logic [W-1:0] s_d,
   input  logic [W-1:0] s_x,
   output logic [W-1:0] y_d,
   output logic [W-1:0] y_x
);

   localparam int unsigned UPPER = (W > 1) ? W - 1 : 1;

   if (W < 1) begin : g_bad_width
      $error("xrail_logic_unit: W must be at least 1");
   end

   logic [W-1:0] a0, a1, ax, b0, b1, bx, s0, s1, sx;
   logic [W-1:0] bw0, bw1, bwx;
   logic         sc0, sc1, scx;
   logic [W-1:0] r0, r1, rx;

   xrl_rail_enc #(.W(W)) u_enc_a (.val_d(a_d), .val_x(a_x), .r0(a0), .r1(a1), .rx(ax));
   xrl_rail_enc #(.W(W)) u_enc_b (.val_d(b_d), .val_x(b_x), .r0(b0), .r1(b1), .rx(bx));
   xrl_rail_enc #(.W(W)) u_enc_s (.val_d(s_d), .val_x(s_x), .r0(s0), .r1(s1), .rx(sx));

   xrl_bitwise #(.W(W)) u_bitwise (
      .op(op),
      .a0(a0), .a1(a1), .ax(ax),
      .b0(b0), .b1(b1), .bx(bx),
      .s0(s0), .s1(s1),
      .y0(bw0), .y1(bw1), .yx(bwx)
   );

   xrl_scalar #(.W(W)) u_scalar (
      .op(op),
      .a0(a0), .a1(a1), .ax(ax),
      .b1(b1), .bx(bx),
      .z0(sc0), .z1(sc1), .zx(scx)
   );

   // result steering: per-bit path, single-bit path, or all unknown
   always_comb begin
      r0 = '0;
      r1 = '0;
      rx = '1;
      if (op_is_bitwise(op)) begin
         r0 = bw0;
         r1 = bw1;
         rx = bwx;
      end else if (op_is_scalar(op)) begin
         r0 = '1;
         r1 = '0;
         rx = '0;
         r0[0] = sc0;
         r1[0] = sc1;
         rx[0] = scx;
      end
   end

   xrl_rail_dec #(.W(W)) u_dec (.r1(r1), .rx(rx), .val_d(y_d), .val_x(y_x));

   // select rail unknown leg only feeds the checks below
   logic sel_x_seen;
   assign sel_x_seen = |sx;

   always_comb begin
      if (op_is_scalar(op) && W > 1) begin
         // R12
         scalar_upper_chk: assert ((y_d >> 1) == '0 && (y_x >> 1) == '0);
      end
      if (op > OP_NE) begin
         // R13
         unused_op_chk: assert (y_x == '1 && y_d == '0);
      end
      if (op == OP_SEL && !sel_x_seen) begin
         // R7
         sel_known_chk: assert (y_x == (a_x & ~s_d | b_x & s_d));
      end
      if (op == OP_INV) begin
         // R3
         inv_mask_chk: assert (y_x == a_x);
      end
   end

   logic [UPPER-1:0] unused_upper;
   assign unused_upper = '0;

endmodule

// File: tb/xrail_logic_unit_tb.sv
module xrail_logic_unit_tb;

   localparam int W = 3;
   localparam int NT = 27; // 3**W

   logic clk = 1'b0;
   always #4 clk = ~clk; // 125 MHz

   logic [3:0]   op;
   logic [W-1:0] a_d, a_x, b_d, b_x, s_d, s_x;
   logic [W-1:0] y_d, y_x;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   xrail_logic_unit #(.W(W)) u_dut (
      .op(op), .a_d(a_d), .a_x(a_x), .b_d(b_d), .b_x(b_x),
      .s_d(s_d), .s_x(s_x), .y_d(y_d), .y_x(y_x)
   );

   // trit codes: 0, 1, 2 = unknown
   function automatic int tr(input logic [W-1:0] d, input logic [W-1:0] x, input int i);
      if (x[i]) return 2;
      return d[i] ? 1 : 0;
   endfunction

   function automatic int t_and(input int p, input int q);
      if (p == 0 || q == 0) return 0;
      if (p == 1 && q == 1) return 1;
      return 2;
   endfunction

   function automatic int t_or(input int p, input int q);
      if (p == 1 || q == 1) return 1;
      if (p == 0 && q == 0) return 0;
      return 2;
   endfunction

   function automatic int t_xor(input int p, input int q);
      if (p == 2 || q == 2) return 2;
      return p ^ q;
   endfunction

   function automatic int t_not(input int p);
      if (p == 2) return 2;
      return 1 - p;
   endfunction

   function automatic string tag_of(input int o);
      case (o)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3, 4: return "R6";
         5: return "R7";
         6, 7: return "R8 R12";
         8: return "R9 R12";
         9: return "R10 R12";
         10, 11: return "R11 R12";
         default: return "R13";
      endcase
   endfunction

   task automatic model(input int o, output logic [W-1:0] ed, output logic [W-1:0] ex);
      int r[W];
      int acc;
      bit any_diff, any_x, all_one, all_zero, any_zero, any_one;
      int par;
      for (int i = 0; i < W; i++) r[i] = 2;
      any_diff = 0; any_x = 0; all_one = 1; all_zero = 1; any_zero = 0; any_one = 0; par = 0;
      for (int i = 0; i < W; i++) begin
         int p, q;
         p = tr(a_d, a_x, i);
         q = tr(b_d, b_x, i);
         if (p == 0) any_zero = 1;
         if (p == 1) any_one = 1;
         if (p != 1) all_one = 0;
         if (p != 0) all_zero = 0;
         if (p == 1) par = par ^ 1;
         if (p == 2 || q == 2) any_x = 1;
         else if (p != q) any_diff = 1;
      end
      if (o <= 5) begin
         for (int i = 0; i < W; i++) begin
            int p, q, s;
            p = tr(a_d, a_x, i);
            q = tr(b_d, b_x, i);
            s = tr(s_d, s_x, i);
            case (o)
               0: r[i] = t_not(p);
               1: r[i] = t_and(p, q);
               2: r[i] = t_or(p, q);
               3: r[i] = t_xor(p, q);
               4: r[i] = t_not(t_xor(p, q));
               default: begin
                  if (s == 0) r[i] = p;
                  else if (s == 1) r[i] = q;
                  else r[i] = (p == q && p != 2) ? p : 2;
               end
            endcase
         end
      end else if (o <= 11) begin
         bit ax_any;
         ax_any = (a_x != '0);
         case (o)
            6: acc = any_zero ? 0 : (all_one ? 1 : 2);
            7: acc = any_one ? 1 : (all_zero ? 0 : 2);
            8: acc = ax_any ? 2 : par;
            9: acc = any_one ? 0 : (all_zero ? 1 : 2);
            10: acc = any_diff ? 0 : (any_x ? 2 : 1);
            default: acc = t_not(any_diff ? 0 : (any_x ? 2 : 1));
         endcase
         r[0] = acc;
         for (int i = 1; i < W; i++) r[i] = 0;
      end
      for (int i = 0; i < W; i++) begin
         ed[i] = (r[i] == 1);
         ex[i] = (r[i] == 2);
      end
   endtask

   task automatic set_trits(input int k, input logic [W-1:0] junk,
                            output logic [W-1:0] d, output logic [W-1:0] x);
      int v;
      v = k;
      for (int i = 0; i < W; i++) begin
         int t;
         t = v % 3;
         v = v / 3;
         x[i] = (t == 2);
         d[i] = (t == 1);
      end
      // R2: junk placed under masked value bits must not matter
      d = d | (x & junk);
   endtask

   task automatic apply(input int o, input int ka, input int kb, input int ks);
      logic [W-1:0] ed, ex, jd, td, tx;
      @(posedge clk);
      jd = W'(n_vec * 5 + 3);
      op = 4'(o);
      set_trits(ka, jd, td, tx); a_d = td; a_x = tx;
      set_trits(kb, ~jd, td, tx); b_d = td; b_x = tx;
      set_trits(ks, jd ^ 3'b101, td, tx); s_d = td; s_x = tx;
      @(negedge clk);
      model(o, ed, ex);
      n_vec++;
      if ((y_d & y_x) != '0) begin
         n_bad++;
         $display("FAIL R1 op=%0d actual d=%b x=%b expected overlap=000", o, y_d, y_x);
      end else if (y_d !== ed || y_x !== ex) begin
         n_bad++;
         $display("FAIL %s R2 op=%0d a=%b/%b b=%b/%b s=%b/%b actual d=%b x=%b expected d=%b x=%b",
                  tag_of(o), o, a_d, a_x, b_d, b_x, s_d, s_x, y_d, y_x, ed, ex);
      end
   endtask

   initial begin
      op = '0; a_d = '0; a_x = '0; b_d = '0; b_x = '0; s_d = '0; s_x = '0;
      // idle inputs: invert of all-zero gives all ones (R3)
      apply(0, 0, 0, 0);
      for (int o = 0; o < 16; o++) begin
         for (int ka = 0; ka < NT; ka++) begin
            for (int kb = 0; kb < NT; kb++) begin
               if (o == 5) begin
                  for (int ks = 0; ks < NT; ks++) apply(o, ka, kb, ks);
               end else begin
                  apply(o, ka, kb, (ka + kb) % NT);
               end
            end
         end
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule